// File: doc/BRIEF.md
# Return-Address Shadow Stack Checker

This block keeps a second, protected stack that holds nothing but return addresses. It watches the stream of retired control transfers. A call event carries the address the callee should return to, and that address is pushed into internal storage. A return event carries the address the program actually went back to. The block pops its own record and compares the two. Only these events write the storage, so an ordinary store cannot reach it, and a return target that the program stack has corrupted cannot match the recorded copy.

A mismatch raises a control-protection exception. The exception is a one-cycle pulse that carries both the recorded and the observed address. A call into a full stack sets an overflow fault and pushes nothing. A return from an empty stack sets an underflow fault. After any of these faults the block locks: it discards every further event until software acknowledges the fault. The acknowledge clears the lock and the fault flags and leaves the stored entries as they were.

Top module: `retaddr_guard`

## Requirements
- R1: After reset, depth_o is 0, and cp_fault_o, overflow_o, underflow_o and locked_o are all 0.
- R2: An accepted call (evt_valid_i=1, evt_kind_i=0) while unlocked and not full raises depth_o by one in the next cycle. depth_o never exceeds DEPTH.
- R3: An accepted return (evt_kind_i=1) whose address equals the most recently pushed entry lowers depth_o by one and raises no exception.
- R4: A return whose address differs from the top entry pulses cp_fault_o for exactly one cycle. In that cycle cp_expected_o shows the top entry and cp_observed_o shows the event address. The entry is consumed (depth_o drops by one) and locked_o becomes 1.
- R5: Entries come back in last-in first-out order, so nested calls that are unwound in reverse order all match.
- R6: A call while depth_o equals DEPTH sets overflow_o and locked_o, leaves depth_o unchanged and writes nothing: after acknowledge, the old top entry still matches.
- R7: A return while depth_o is 0 sets underflow_o and locked_o, keeps depth_o at 0 and does not pulse cp_fault_o.
- R8: While locked_o is 1, call and return events change nothing: depth_o stays the same and no new exception is raised.
- R9: ack_i asserted while locked_o is 1 clears locked_o, overflow_o and underflow_o in the next cycle. Stored entries and depth_o are kept.
- R10: cp_expected_o and cp_observed_o are 0 in every cycle in which cp_fault_o is 0.
- R11: A cycle with evt_valid_i=0 leaves depth_o unchanged, whatever evt_kind_i and evt_addr_i hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | An event is present this cycle |
| evt_kind_i | input | 1 | 0 = call, 1 = return |
| evt_addr_i | input | ADDR_W | Return address for a call; actual target for a return |
| ack_i | input | 1 | Clears the lock and the fault flags |
| cp_fault_o | output | 1 | One-cycle control-protection exception on a mismatch |
| cp_expected_o | output | ADDR_W | Recorded return address during the exception cycle |
| cp_observed_o | output | ADDR_W | Observed return target during the exception cycle |
| depth_o | output | $clog2(DEPTH+1) | Number of entries held |
| overflow_o | output | 1 | Sticky: a call arrived at a full stack |
| underflow_o | output | 1 | Sticky: a return arrived at an empty stack |
| locked_o | output | 1 | Events are ignored until acknowledge |

## Verification
The bench builds the block with DEPTH=4 and the full 64-bit address width. The small depth brings the full boundary within reach in four calls, so both the overflow path and the check that a refused push left the top entry intact run in a few cycles. The 64-bit width keeps every comparator lane in use, and the mismatch test uses an address that differs from the recorded one only in the upper lanes.

// File: rtl/retaddr_guard_pkg.sv
package retaddr_guard_pkg;

    typedef enum logic {
        EV_CALL = 1'b0,
        EV_RET  = 1'b1
    } evt_kind_e;

endpackage

// File: rtl/rag_store.sv
// Flop-based return-address storage: one write port, one AND-OR read port.
module rag_store #(
    parameter int DEPTH   = 32,
    parameter int ADDR_W  = 64,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               wr_en_i,
    input  logic [DEPTH_W-1:0] wr_idx_i,
    input  logic [ADDR_W-1:0]  wr_data_i,
    input  logic [DEPTH_W-1:0] rd_idx_i,
    output logic [ADDR_W-1:0]  rd_data_o
);

    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (wr_en_i && (wr_idx_i == DEPTH_W'(i))) begin
                slot_q[i] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == DEPTH_W'(i)) begin
                rd_data_o = rd_data_o | slot_q[i];
            end
        end
    end

endmodule

// File: rtl/rag_cmp.sv
// Address comparator split into lanes to keep the reduction tree shallow.
module rag_cmp #(
    parameter int ADDR_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    output logic              differ_o
);

    localparam int NLANES = (ADDR_W + LANE_W - 1) / LANE_W;
    localparam int PAD_W  = NLANES * LANE_W;

    logic [PAD_W-1:0]  a_pad;
    logic [PAD_W-1:0]  b_pad;
    logic [NLANES-1:0] lane_ne;

    assign a_pad = PAD_W'(a_i);
    assign b_pad = PAD_W'(b_i);

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        assign lane_ne[l] = |(a_pad[l*LANE_W +: LANE_W] ^ b_pad[l*LANE_W +: LANE_W]);
    end

    assign differ_o = |lane_ne;

endmodule

// File: rtl/retaddr_guard.sv
module retaddr_guard
    import retaddr_guard_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int ADDR_W  = 64,
    parameter int LANE_W  = 16,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               evt_valid_i,
    input  logic               evt_kind_i,
    input  logic [ADDR_W-1:0]  evt_addr_i,
    input  logic               ack_i,
    output logic               cp_fault_o,
    output logic [ADDR_W-1:0]  cp_expected_o,
    output logic [ADDR_W-1:0]  cp_observed_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               overflow_o,
    output logic               underflow_o,
    output logic               locked_o
);

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
        logic               locked;
        logic               ovf;
        logic               unf;
        logic               fault;
        logic [ADDR_W-1:0]  exp_addr;
        logic [ADDR_W-1:0]  obs_addr;
    } guard_st_t;

    guard_st_t st_q, st_d;

    logic               push;
    logic [DEPTH_W-1:0] top_idx;
    logic [ADDR_W-1:0]  top_addr;
    logic               addr_differ;
    logic               is_full;
    logic               is_empty;
    evt_kind_e          kind;

    assign kind     = evt_kind_e'(evt_kind_i);
    assign is_full  = (st_q.depth == DEPTH_W'(DEPTH));
    assign is_empty = (st_q.depth == '0);
    assign top_idx  = st_q.depth - DEPTH_W'(1);

    rag_store #(
        .DEPTH   (DEPTH),
        .ADDR_W  (ADDR_W),
        .DEPTH_W (DEPTH_W)
    ) store_i (
        .clk_i     (clk_i),
        .wr_en_i   (push),
        .wr_idx_i  (st_q.depth),
        .wr_data_i (evt_addr_i),
        .rd_idx_i  (top_idx),
        .rd_data_o (top_addr)
    );

    rag_cmp #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) cmp_i (
        .a_i      (top_addr),
        .b_i      (evt_addr_i),
        .differ_o (addr_differ)
    );

    always_comb begin
        st_d          = st_q;
        st_d.fault    = 1'b0;
        st_d.exp_addr = '0;
        st_d.obs_addr = '0;
        push          = 1'b0;

        if (st_q.locked) begin
            if (ack_i) begin
                st_d.locked = 1'b0;
                st_d.ovf    = 1'b0;
                st_d.unf    = 1'b0;
            end
        end else if (evt_valid_i) begin
            if (kind == EV_CALL) begin
                if (is_full) begin
                    st_d.ovf    = 1'b1;
                    st_d.locked = 1'b1;
                end else begin
                    push       = 1'b1;
                    st_d.depth = st_q.depth + DEPTH_W'(1);
                end
            end else begin
                if (is_empty) begin
                    st_d.unf    = 1'b1;
                    st_d.locked = 1'b1;
                end else begin
                    st_d.depth = top_idx;
                    if (addr_differ) begin
                        st_d.fault    = 1'b1;
                        st_d.exp_addr = top_addr;
                        st_d.obs_addr = evt_addr_i;
                        st_d.locked   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cp_fault_o    = st_q.fault;
    assign cp_expected_o = st_q.exp_addr;
    assign cp_observed_o = st_q.obs_addr;
    assign depth_o       = st_q.depth;
    assign overflow_o    = st_q.ovf;
    assign underflow_o   = st_q.unf;
    assign locked_o      = st_q.locked;

endmodule

// File: rtl/retaddr_guard_chk.sv
module retaddr_guard_chk #(
    parameter int DEPTH   = 32,
    parameter int ADDR_W  = 64,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               evt_valid_i,
    input logic               evt_kind_i,
    input logic               ack_i,
    input logic               cp_fault_o,
    input logic [ADDR_W-1:0]  cp_expected_o,
    input logic [ADDR_W-1:0]  cp_observed_o,
    input logic [DEPTH_W-1:0] depth_o,
    input logic               overflow_o,
    input logic               underflow_o,
    input logic               locked_o
);

    AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |=> (depth_o == '0 && !locked_o && !cp_fault_o)); // R1

    AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) depth_o <= DEPTH_W'(DEPTH)); // R2

    AST_FAULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) cp_fault_o |=> !cp_fault_o); // R4

    AST_FAULT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni) cp_fault_o |-> locked_o); // R4

    AST_OVERFLOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!locked_o && evt_valid_i && !evt_kind_i && depth_o == DEPTH_W'(DEPTH)) |=> (overflow_o && $stable(depth_o))); // R6

    AST_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!locked_o && evt_valid_i && evt_kind_i && depth_o == '0) |=> (underflow_o && locked_o && depth_o == '0 && !cp_fault_o)); // R7

    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni) locked_o |=> ($stable(depth_o) && !cp_fault_o)); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && ack_i) |=> (!locked_o && !overflow_o && !underflow_o)); // R9

    AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cp_fault_o |-> (cp_expected_o == '0 && cp_observed_o == '0)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !evt_valid_i |=> $stable(depth_o)); // R11

endmodule

bind retaddr_guard retaddr_guard_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) chk_i (.*);

// File: tb/retaddr_guard_tb_top.sv
`timescale 1ns/1ps
module retaddr_guard_tb_top;

    localparam int DEPTH   = 4;
    localparam int ADDR_W  = 64;
    localparam int DEPTH_W = $clog2(DEPTH + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               evt_valid = 1'b0;
    logic               evt_kind = 1'b0;
    logic [ADDR_W-1:0]  evt_addr = '0;
    logic               ack = 1'b0;
    logic               cp_fault;
    logic [ADDR_W-1:0]  cp_expected;
    logic [ADDR_W-1:0]  cp_observed;
    logic [DEPTH_W-1:0] depth;
    logic               ovf;
    logic               unf;
    logic               locked;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    retaddr_guard #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .evt_valid_i   (evt_valid),
        .evt_kind_i    (evt_kind),
        .evt_addr_i    (evt_addr),
        .ack_i         (ack),
        .cp_fault_o    (cp_fault),
        .cp_expected_o (cp_expected),
        .cp_observed_o (cp_observed),
        .depth_o       (depth),
        .overflow_o    (ovf),
        .underflow_o   (unf),
        .locked_o      (locked)
    );

    task automatic check(input string req, input string what, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; return at the next falling edge.
    task automatic cycle(input logic v, input logic k, input logic [ADDR_W-1:0] a, input logic ak);
        evt_valid = v;
        evt_kind  = k;
        evt_addr  = a;
        ack       = ak;
        @(negedge clk);
        evt_valid = 1'b0;
        evt_kind  = 1'b0;
        evt_addr  = '0;
        ack       = 1'b0;
    endtask

    task automatic call_ev(input logic [ADDR_W-1:0] a);
        cycle(1'b1, 1'b0, a, 1'b0);
    endtask

    task automatic ret_ev(input logic [ADDR_W-1:0] a);
        cycle(1'b1, 1'b1, a, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "depth", ADDR_W'(depth), 0);
        check("R1", "fault", ADDR_W'(cp_fault), 0);
        check("R1", "overflow", ADDR_W'(ovf), 0);
        check("R1", "underflow", ADDR_W'(unf), 0);
        check("R1", "locked", ADDR_W'(locked), 0);
        check("R10", "expected idle", cp_expected, 0);
    endtask

    task automatic t_idle();
        cycle(1'b0, 1'b0, 64'hDEAD_BEEF_0000_0001, 1'b0);
        check("R11", "depth after idle call-like", ADDR_W'(depth), 0);
        cycle(1'b0, 1'b1, 64'hDEAD_BEEF_0000_0002, 1'b0);
        check("R11", "depth after idle return-like", ADDR_W'(depth), 0);
        check("R11", "no fault", ADDR_W'(cp_fault), 0);
    endtask

    task automatic t_match();
        call_ev(64'h0000_7FFF_1234_5678);
        check("R2", "depth after call", ADDR_W'(depth), 1);
        ret_ev(64'h0000_7FFF_1234_5678);
        check("R3", "depth after matching return", ADDR_W'(depth), 0);
        check("R3", "no fault", ADDR_W'(cp_fault), 0);
    endtask

    task automatic t_lifo();
        for (int i = 1; i <= 3; i++) begin
            call_ev(64'h1000 * i);
            check("R2", "depth rising", ADDR_W'(depth), ADDR_W'(i));
        end
        for (int i = 3; i >= 1; i--) begin
            ret_ev(64'h1000 * i);
            check("R5", "lifo no fault", ADDR_W'(cp_fault), 0);
            check("R5", "depth falling", ADDR_W'(depth), ADDR_W'(i - 1));
        end
    endtask

    task automatic t_mismatch();
        call_ev(64'h0000_0000_0000_1111);
        call_ev(64'h0000_0000_0000_2222);
        ret_ev(64'h5A00_0000_0000_2222);
        check("R4", "fault pulse", ADDR_W'(cp_fault), 1);
        check("R4", "expected addr", cp_expected, 64'h0000_0000_0000_2222);
        check("R4", "observed addr", cp_observed, 64'h5A00_0000_0000_2222);
        check("R4", "entry consumed", ADDR_W'(depth), 1);
        check("R4", "locked", ADDR_W'(locked), 1);
        cycle(1'b0, 1'b0, '0, 1'b0);
        check("R4", "pulse ends", ADDR_W'(cp_fault), 0);
        check("R10", "expected cleared", cp_expected, 0);
        check("R10", "observed cleared", cp_observed, 0);
        call_ev(64'h5);
        check("R8", "call ignored depth", ADDR_W'(depth), 1);
        ret_ev(64'h0);
        check("R8", "return ignored depth", ADDR_W'(depth), 1);
        check("R8", "no new fault", ADDR_W'(cp_fault), 0);
        cycle(1'b0, 1'b0, '0, 1'b1);
        check("R9", "unlocked", ADDR_W'(locked), 0);
        check("R9", "depth kept", ADDR_W'(depth), 1);
        ret_ev(64'h0000_0000_0000_1111);
        check("R9", "entry kept, no fault", ADDR_W'(cp_fault), 0);
        check("R9", "depth after", ADDR_W'(depth), 0);
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= DEPTH; i++) call_ev(64'hA0 + i);
        check("R2", "full depth", ADDR_W'(depth), DEPTH);
        call_ev(64'hBAD);
        check("R6", "overflow flag", ADDR_W'(ovf), 1);
        check("R6", "locked", ADDR_W'(locked), 1);
        check("R6", "depth held", ADDR_W'(depth), DEPTH);
        cycle(1'b0, 1'b0, '0, 1'b1);
        check("R9", "overflow cleared", ADDR_W'(ovf), 0);
        ret_ev(64'hA0 + DEPTH);
        check("R6", "top not overwritten", ADDR_W'(cp_fault), 0);
        for (int i = DEPTH - 1; i >= 1; i--) ret_ev(64'hA0 + i);
        check("R5", "unwound", ADDR_W'(depth), 0);
        check("R5", "no fault on unwind", ADDR_W'(cp_fault), 0);
    endtask

    task automatic t_underflow();
        ret_ev(64'h77);
        check("R7", "underflow flag", ADDR_W'(unf), 1);
        check("R7", "locked", ADDR_W'(locked), 1);
        check("R7", "depth zero", ADDR_W'(depth), 0);
        check("R7", "no exception", ADDR_W'(cp_fault), 0);
        cycle(1'b0, 1'b0, '0, 1'b1);
        check("R9", "underflow cleared", ADDR_W'(unf), 0);
        check("R9", "unlocked", ADDR_W'(locked), 0);
        call_ev(64'h99);
        check("R9", "accepts after ack", ADDR_W'(depth), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_match();
        t_lifo();
        t_mismatch();
        t_overflow();
        t_underflow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule